// File: doc/BRIEF.md
# Status Register Transfer Unit

This block keeps the processor's live status word and one saved copy of it, and performs the two kinds of status transfer: reading a status word out onto a data bus, and writing into one. A write can replace every writable bit or touch only the four condition flags. Its operand comes from a register or from an already expanded immediate. Every transfer finishes in one clock. A transfer whose condition did not pass does nothing.

The status word has the flags N, Z, C and V in bits 31, 30, 29 and 28, control bits in 7 to 5 and the processor mode in 4 to 0. Bits 27 to 8 are reserved. They read as zero and no write can change them. A full-word write therefore merges the operand into the word under a mask; it does not load the word whole. A full-word write from an immediate is refused and reported on an error output. The live flags and the live mode are always present on their own outputs.

Read and write have separate strobes, so a read and a write can occur in the same cycle. The decoder in front of the block and the register file behind it are separate blocks.

Top module: `psr_xfer_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the live word loads mode `RESET_MODE` (default 5'b10011) with all flags and other bits zero, and the saved word clears to zero.
- R2: When `rd_en` and `cond_pass` are both high, `rd_data` shows the word picked by `rd_saved` (0 = live, 1 = saved) in the same cycle; otherwise `rd_data` is zero.
- R3: A passing full-word write (`wr_flags_only` = 0) copies operand bits 31:28 and 7:0 into the target, visible from the next clock edge.
- R4: A passing flags-only write (`wr_flags_only` = 1) copies operand bits 31, 30, 29, 28 into N, Z, C, V and leaves bits 27:0 of the target unchanged.
- R5: Bits 27:8 of both words stay zero whatever the operand of any write.
- R6: `wr_saved` picks the target of a write (0 = live, 1 = saved); the other word is not changed.
- R7: A passing write with `wr_imm` = 1 and `wr_flags_only` = 0 raises `err` in the same cycle and changes neither word. `err` is low in every other case.
- R8: With `cond_pass` low, neither word changes, `err` stays low and `rd_data` is zero.
- R9: A read and a write to the same word in the same cycle return the value from before the write.
- R10: `flags` always equals live bits 31:28 (N in bit 3) and `mode` equals live bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_saved | input | 1 | Read target: 0 live, 1 saved |
| wr_en | input | 1 | Write strobe |
| wr_saved | input | 1 | Write target: 0 live, 1 saved |
| wr_flags_only | input | 1 | 1 writes only the flag field |
| wr_imm | input | 1 | 1 marks the operand as an immediate |
| operand | input | 32 | Write operand |
| cond_pass | input | 1 | Condition of the current transfer passed |
| rd_data | output | 32 | Read result |
| flags | output | 4 | Live N, Z, C, V |
| mode | output | 5 | Live mode field |
| err | output | 1 | Illegal full-word immediate write |

## Verification
A read and a write can fall in the same cycle. The bench provokes this by raising both strobes on the same word, with every mix of target and write kind, and on different words. The scoreboard expects the read to show the word as it stood before the clock edge. One cycle later it expects the flags and mode outputs to show the merged value. Refused immediate writes and failed conditions are mixed into the same sequences, and the scoreboard checks that they leave the state unchanged.

// File: rtl/psr_pkg.sv
// Shared constants for the status register transfer unit.
// Assumes a 32-bit status word with flags at the top and mode at the bottom.
package psr_pkg;
    localparam int PSR_W     = 32;
    localparam int FLAG_W    = 4;
    localparam int MODE_W    = 5;
    localparam int FLAG_LSB  = PSR_W - FLAG_W;   // N,Z,C,V at 31..28
    localparam int CTRL_W    = 8;                // bits 7..0 writable
    localparam logic [PSR_W-1:0] FLAG_MASK = {{FLAG_W{1'b1}}, {(PSR_W-FLAG_W){1'b0}}};
    localparam logic [PSR_W-1:0] CTRL_MASK = {{(PSR_W-CTRL_W){1'b0}}, {CTRL_W{1'b1}}};
    localparam logic [PSR_W-1:0] FULL_MASK = FLAG_MASK | CTRL_MASK;
    localparam int N_WORDS   = 2;                // 0 live, 1 saved
endpackage

// File: rtl/psr_xfer_ctrl.sv
// Turns the decoded strobes into per-word write enables and the error flag.
// Assumes operand already expanded; only legality of immediates is judged.
module psr_xfer_ctrl
    import psr_pkg::*;
(
    input  logic               wr_en,
    input  logic               wr_saved,
    input  logic               wr_flags_only,
    input  logic               wr_imm,
    input  logic               cond_pass,
    output logic [N_WORDS-1:0] we,
    output logic               err
);
    logic live_wr;

    // Qualify the write and split it by target.
    always_comb begin
        live_wr = wr_en && cond_pass;
        err     = live_wr && wr_imm && !wr_flags_only;
        we      = '0;
        if (live_wr && !err) begin
            we[wr_saved] = 1'b1;
        end
    end
endmodule

// File: rtl/psr_write_merge.sv
// Masked merge of an operand into a status word.
// Assumes reserved bits are outside both masks, so they always keep cur.
module psr_write_merge
    import psr_pkg::*;
(
    input  logic [PSR_W-1:0] cur,
    input  logic [PSR_W-1:0] operand,
    input  logic             flags_only,
    output logic [PSR_W-1:0] nxt
);
    logic [PSR_W-1:0] mask;

    // Pick the mask and merge.
    always_comb begin
        mask = flags_only ? FLAG_MASK : FULL_MASK;
        nxt  = (cur & ~mask) | (operand & mask);
    end
endmodule

// File: rtl/psr_word_reg.sv
// One status word register with its own reset value.
// Assumes the reset value has zero reserved bits.
module psr_word_reg
    import psr_pkg::*;
#(
    parameter logic [PSR_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PSR_W-1:0] d,
    output logic [PSR_W-1:0] q
);
    // Hold or load the word.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= d;
    end

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
    // R5
    resv_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(q[FLAG_LSB-1:CTRL_W]));
endmodule

// File: rtl/psr_xfer_unit.sv
// Status register transfer unit: live and saved status words, single-cycle
// read and masked write. Assumes one decoded transfer of each kind per cycle.
module psr_xfer_unit
    import psr_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_saved,
    input  logic              wr_en,
    input  logic              wr_saved,
    input  logic              wr_flags_only,
    input  logic              wr_imm,
    input  logic [PSR_W-1:0]  operand,
    input  logic              cond_pass,
    output logic [PSR_W-1:0]  rd_data,
    output logic [FLAG_W-1:0] flags,
    output logic [MODE_W-1:0] mode,
    output logic              err
);
    localparam logic [PSR_W-1:0] LIVE_RST = {{(PSR_W-MODE_W){1'b0}}, RESET_MODE};

    logic [N_WORDS-1:0]            we;
    logic [N_WORDS-1:0][PSR_W-1:0] word_q;
    logic [PSR_W-1:0]              tgt_cur;
    logic [PSR_W-1:0]              tgt_nxt;

    psr_xfer_ctrl ctrl_i (
        .wr_en(wr_en), .wr_saved(wr_saved), .wr_flags_only(wr_flags_only),
        .wr_imm(wr_imm), .cond_pass(cond_pass), .we(we), .err(err)
    );

    // Select the word being written.
    always_comb tgt_cur = word_q[wr_saved];

    psr_write_merge merge_i (
        .cur(tgt_cur), .operand(operand), .flags_only(wr_flags_only), .nxt(tgt_nxt)
    );

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        psr_word_reg #(.RST_VAL(g == 0 ? LIVE_RST : '0)) reg_i (
            .clk(clk), .rst_n(rst_n), .we(we[g]), .d(tgt_nxt), .q(word_q[g])
        );
    end

    // Same-cycle read of the registered (pre-write) word.
    always_comb rd_data = (rd_en && cond_pass) ? word_q[rd_saved] : '0;

    // Live field outputs.
    always_comb begin
        flags = word_q[0][PSR_W-1:FLAG_LSB];
        mode  = word_q[0][MODE_W-1:0];
    end

    // R7
    err_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> ($stable(word_q[0]) && $stable(word_q[1])));
    // R8
    cond_fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass |=> ($stable(word_q[0]) && $stable(word_q[1])));
    // R4
    flag_write_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cond_pass && wr_flags_only && !wr_saved)
            |=> $stable(word_q[0][FLAG_LSB-1:0]));
    // R9
    read_pre_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cond_pass && !rd_saved) |=> ($past(rd_data) == $past(word_q[0])));
endmodule

// File: tb/psr_xfer_unit_tb_top.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module psr_xfer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 0, rd_saved = 0, wr_en = 0, wr_saved = 0;
    logic        wr_flags_only = 0, wr_imm = 0, cond_pass = 0;
    logic [31:0] operand = '0;
    logic [31:0] rd_data;
    logic [3:0]  flags;
    logic [4:0]  mode;
    logic        err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       req;
        logic [31:0] rd;
        logic        er;
        logic [3:0]  fl;
        logic [4:0]  md;
    } exp_t;
    exp_t q[$];

    logic [31:0] m_live, m_sav;
    localparam logic [31:0] M_FLAG = 32'hF000_0000;
    localparam logic [31:0] M_FULL = 32'hF000_00FF;

    always #5 clk = ~clk;

    psr_xfer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_saved(rd_saved),
        .wr_en(wr_en), .wr_saved(wr_saved), .wr_flags_only(wr_flags_only),
        .wr_imm(wr_imm), .operand(operand), .cond_pass(cond_pass),
        .rd_data(rd_data), .flags(flags), .mode(mode), .err(err)
    );

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one transfer at the falling edge and predict its outputs.
    task automatic xfer(string req, bit r, bit rs, bit w, bit ws, bit fo, bit im,
                        logic [31:0] op, bit cp);
        exp_t e;
        logic [31:0] mask, tgt;
        bit bad;
        @(negedge clk);
        rd_en = r; rd_saved = rs; wr_en = w; wr_saved = ws;
        wr_flags_only = fo; wr_imm = im; operand = op; cond_pass = cp;
        bad  = w && cp && im && !fo;
        e.req = req;
        e.rd  = (r && cp) ? (rs ? m_sav : m_live) : 32'h0;
        e.er  = bad;
        e.fl  = m_live[31:28];
        e.md  = m_live[4:0];
        q.push_back(e);
        if (w && cp && !bad) begin
            mask = fo ? M_FLAG : M_FULL;
            tgt  = ws ? m_sav : m_live;
            tgt  = (tgt & ~mask) | (op & mask);
            if (ws) m_sav = tgt; else m_live = tgt;
        end
    endtask

    // Compare the oldest prediction a little after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.req, "rd_data", rd_data, e.rd);
                cmp(e.req, "err", {31'b0, err}, {31'b0, e.er});
                cmp(e.req, "flags", {28'b0, flags}, {28'b0, e.fl});
                cmp(e.req, "mode", {27'b0, mode}, {27'b0, e.md});
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_live = 32'h0000_0013;
        m_sav  = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, R2 reads of both words
        xfer("R1", 1, 0, 0, 0, 0, 0, 32'h0, 1);
        xfer("R1", 1, 1, 0, 0, 0, 0, 32'h0, 1);
        // R2 no read strobe gives zero
        xfer("R2", 0, 0, 0, 0, 0, 0, 32'h0, 1);
        // R3 R5 full write to live, reserved bits in operand ignored
        xfer("R3", 0, 0, 1, 0, 0, 0, 32'hA5FF_FF1F, 1);
        xfer("R5", 1, 0, 0, 0, 0, 0, 32'h0, 1);
        // R4 flags-only write, register operand
        xfer("R4", 0, 0, 1, 0, 1, 0, 32'h3FFF_FFFF, 1);
        xfer("R4", 1, 0, 0, 0, 0, 0, 32'h0, 1);
        // R4 flags-only write with immediate is legal
        xfer("R4", 0, 0, 1, 0, 1, 1, 32'hC000_0000, 1);
        // R6 write to saved leaves live alone
        xfer("R6", 0, 0, 1, 1, 0, 0, 32'h5123_45D2, 1);
        xfer("R6", 1, 1, 0, 0, 0, 0, 32'h0, 1);
        // R7 full immediate write refused
        xfer("R7", 0, 0, 1, 0, 0, 1, 32'hFFFF_FFFF, 1);
        xfer("R7", 1, 0, 1, 1, 0, 1, 32'h0000_0000, 1);
        // R8 failed condition: no write, no error, no read
        xfer("R8", 1, 0, 1, 0, 0, 1, 32'h0000_0000, 0);
        xfer("R8", 1, 0, 1, 0, 0, 0, 32'h0000_0000, 0);
        xfer("R8", 1, 0, 0, 0, 0, 0, 32'h0, 1);
        // R9 same-cycle read and write to same word
        xfer("R9", 1, 0, 1, 0, 0, 0, 32'h9000_0011, 1);
        xfer("R9", 1, 0, 1, 0, 1, 0, 32'h6000_0000, 1);
        xfer("R9", 1, 1, 1, 1, 1, 0, 32'hF000_0000, 1);
        xfer("R9", 1, 1, 1, 0, 0, 0, 32'h0000_001B, 1);
        // R10 live fields after many patterns
        for (int i = 0; i < 24; i++) begin
            xfer("R10", 1, i[0], 1, i[1], i[2], i[3] & i[2], (32'h1357_9BDF * (i + 3)) ^ {i[7:0], 24'h0}, 1);
        end
        xfer("R10", 1, 0, 0, 0, 0, 0, 32'h0, 1);
        xfer("R5", 1, 1, 0, 0, 0, 0, 32'h0, 1);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule